// File: doc/BRIEF.md
# Serial Memory Command Controller

This block is a serial-peripheral slave, working in clock modes 0 and 3, that sits in front of a 2048-byte internal byte store. All serial inputs are oversampled in the system clock domain. Each transaction opens with an 8-bit opcode, sent most significant bit first. The opcode selects one of the following:
- set or clear the write-enable latch
- set or clear a general-purpose flag
- stream the status byte
- write the status byte
- stream memory from a 16-bit start address
- fill a 32-byte page

A nonvolatile write is modelled as a self-timed busy window whose length is a parameter in clock cycles. The store, or the status byte, is updated in the cycle that window opens. The watchdog-period field and the flag bit leave the block as plain outputs for a neighbouring supervisor.

The write guards follow a fixed order. A write needs the enable latch set beforehand. It takes effect only when chip select is released exactly on a byte boundary. A two-bit lock field write-protects the top quarter, the top half or all of the store. A lock-enable status bit, combined with a low level on the write-protect pin, freezes the status byte.

Top module: `serial_mem_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00, soEn is low, wdSel is 0 and flagOut is 0.
- R2: si is sampled on rising sck and so changes on falling sck, most significant bit first, in both clock mode 0 and clock mode 3. soEn is high exactly while csN is low.
- R3: Opcode 0x06 sets the enable latch (status bit 1) only if csN rises right after its eighth bit; any further sck edge voids it. Opcode 0x04 clears both the enable latch and the flag.
- R4: Opcode 0x00 sets the flag, seen on flagOut and in status bit 6.
- R5: Opcode 0x05 streams the status byte repeatedly while clocks continue. The byte is laid out as bit 7 lock-enable, bit 6 flag, bits 5:4 watchdog period, bits 3:2 block lock, bit 1 enable latch, bit 0 write-in-progress.
- R6: Opcode 0x03 takes a 16-bit address, of which bits 15:11 are ignored, then streams bytes from incrementing addresses. The address wraps from 0x7FF to 0x000.
- R7: Opcode 0x02 is accepted only with the enable latch set. It takes a 16-bit address, then data bytes stored at incrementing addresses that wrap inside the current 32-byte page.
- R8: A write commits only if csN rises on a byte boundary after at least one data byte. Otherwise the store is unchanged and the enable latch stays set.
- R9: A committed write of the store or of the status byte holds write-in-progress at 1 for BUSY_CYCLES clocks (default 400). The enable latch is cleared when that window ends.
- R10: While write-in-progress is 1, every opcode other than 0x05 is ignored.
- R11: Lock field 01 protects 0x600–0x7FF, 10 protects 0x400–0x7FF and 11 protects the whole store. Protected bytes are left unchanged by a committed write, while unprotected bytes are written.
- R12: Opcode 0x01 with the enable latch set writes status bits 7:2 from its data byte and discards data bits 1:0. wdSel and flagOut follow the new value.
- R13: When status bit 7 is 1 and wpN is low, opcode 0x01 is refused and the enable latch stays set. With wpN high it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rstN | input | 1 | Active-low synchronous reset (power-up state) |
| csN | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| wpN | input | 1 | Active-low status write-protect pin |
| so | output | 1 | Serial data out |
| soEn | output | 1 | Output enable for so; low means high impedance |
| wdSel | output | 2 | Watchdog period field for the supervisor |
| flagOut | output | 1 | General-purpose flag for the supervisor |

## Verification
The serial decoder keeps accepting transactions while the self-timed busy window counts down. A new opcode can therefore be decoded in a cycle in which write-in-progress is still high. The bench provokes this by issuing a status read and a flag-set opcode straight after a committed page write. The read must show both write-in-progress and the enable latch at 1. flagOut must still be 0 after the window closes, and a later status read must show the latch cleared.

// File: rtl/smc_pkg.sv
package smc_pkg;
  localparam int MEM_AW = 11;  // byte address width of the store
  localparam int PG_AW  = 5;   // address bits inside one page

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_SFLB  = 8'h00;
  localparam logic [7:0] OP_RFLB  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  typedef enum logic [2:0] {
    ST_OPC, ST_ADDR, ST_WDATA, ST_RDATA, ST_STOUT, ST_SRIN, ST_HOLD, ST_IGNORE
  } seqState_t;

  typedef struct packed {
    logic              setWel;
    logic              clrWel;
    logic              setFlag;
    logic              clrFlag;
    logic              bufClr;
    logic              bufWr;
    logic              memCommit;
    logic              statWr;
    logic [MEM_AW-1:0] bufAddr;
    logic [7:0]        bufData;
    logic [5:0]        statBits;   // new status bits 7:2
  } dpStrobe_t;
endpackage

// File: rtl/smc_ctrl.sv
module smc_ctrl
  import smc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sck,
  input  logic              si,
  input  logic              wpN,
  input  logic [7:0]        statusIn,
  input  logic [7:0]        rdByte,
  output logic [MEM_AW-1:0] rdAddr,
  output dpStrobe_t         str,
  output logic              so
);
  localparam int HI_W = MEM_AW - 8;

  seqState_t         state;
  logic              sckPrev, csPrev, addrByte, isRead, gotData;
  logic [2:0]        bitCnt;
  logic [7:0]        shReg, outSh, opReg;
  logic [5:0]        statHold;
  logic [HI_W-1:0]   addrHi;
  logic [MEM_AW-1:0] addr, newAddr, pageNext;
  logic [PG_AW-1:0]  lowInc;
  logic [7:0]        newShift;
  logic              sckRise, sckFall, csRise, byteDone;
  logic              welNow, busyNow, romLock;

  always_comb begin
    sckRise  = !csN && sck && !sckPrev;
    sckFall  = !csN && !sck && sckPrev;
    csRise   = csN && !csPrev;
    newShift = {shReg[6:0], si};
    byteDone = sckRise && (bitCnt == 3'd7);
    newAddr  = {addrHi, newShift};
    lowInc   = addr[PG_AW-1:0] + 1'b1;
    pageNext = {addr[MEM_AW-1:PG_AW], lowInc};
    rdAddr   = (state == ST_ADDR) ? newAddr : addr;
    welNow   = statusIn[1];
    busyNow  = statusIn[0];
    romLock  = statusIn[7] && !wpN;

    str          = '0;
    str.statBits = statHold;
    if (csRise && state == ST_HOLD && bitCnt == 3'd0) begin
      case (opReg)
        OP_WREN: str.setWel  = 1'b1;
        OP_SFLB: str.setFlag = 1'b1;
        OP_RFLB: begin str.clrWel = 1'b1; str.clrFlag = 1'b1; end
        OP_WRSR: str.statWr  = welNow && !romLock;
        default: ;
      endcase
    end
    if (csRise && state == ST_WDATA && bitCnt == 3'd0 && gotData)
      str.memCommit = 1'b1;
    if (byteDone && state == ST_ADDR && addrByte && !isRead) begin
      str.bufClr  = 1'b1;
      str.bufAddr = newAddr;
    end
    if (byteDone && state == ST_WDATA) begin
      str.bufWr   = 1'b1;
      str.bufAddr = addr;
      str.bufData = newShift;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_OPC;   sckPrev <= 1'b0; csPrev <= 1'b1;
      bitCnt <= '0;      shReg <= '0;     outSh <= '0;
      opReg <= '0;       statHold <= '0;  addrHi <= '0;
      addr <= '0;        addrByte <= 1'b0; isRead <= 1'b0;
      gotData <= 1'b0;   so <= 1'b0;
    end else begin
      sckPrev <= sck;
      csPrev  <= csN;
      if (csN) begin
        state <= ST_OPC; bitCnt <= '0; addrByte <= 1'b0;
        outSh <= '0;     gotData <= 1'b0;
      end else begin
        if (sckFall) begin
          so    <= outSh[7];
          outSh <= {outSh[6:0], 1'b0};
        end
        if (sckRise) begin
          shReg  <= newShift;
          bitCnt <= bitCnt + 3'd1;
          if (state == ST_HOLD) state <= ST_IGNORE;
        end
        if (byteDone) begin
          case (state)
            ST_OPC: begin
              opReg <= newShift;
              if (busyNow && newShift != OP_RDSR) state <= ST_IGNORE;
              else begin
                case (newShift)
                  OP_WREN, OP_SFLB, OP_RFLB: state <= ST_HOLD;
                  OP_RDSR:  begin state <= ST_STOUT; outSh <= statusIn; end
                  OP_WRSR:  state <= ST_SRIN;
                  OP_READ:  begin state <= ST_ADDR; isRead <= 1'b1; end
                  OP_WRITE: begin
                    state  <= welNow ? ST_ADDR : ST_IGNORE;
                    isRead <= 1'b0;
                  end
                  default:  state <= ST_IGNORE;
                endcase
              end
            end
            ST_ADDR: begin
              if (!addrByte) begin
                addrHi   <= newShift[HI_W-1:0];
                addrByte <= 1'b1;
              end else if (isRead) begin
                state <= ST_RDATA;
                outSh <= rdByte;
                addr  <= newAddr + 1'b1;
              end else begin
                state <= ST_WDATA;
                addr  <= newAddr;
              end
            end
            ST_WDATA: begin gotData <= 1'b1; addr <= pageNext; end
            ST_RDATA: begin outSh <= rdByte; addr <= addr + 1'b1; end
            ST_STOUT: outSh <= statusIn;
            ST_SRIN:  begin statHold <= newShift[7:2]; state <= ST_HOLD; end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/smc_dp.sv
module smc_dp
  import smc_pkg::*;
#(
  parameter int BUSY_CYCLES = 400
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wpN,
  input  dpStrobe_t         str,
  input  logic [MEM_AW-1:0] rdAddr,
  output logic [7:0]        rdByte,
  output logic [7:0]        statusOut,
  output logic [1:0]        wdSel,
  output logic              flagOut
);
  localparam int DEPTH = 1 << MEM_AW;
  localparam int PG_SZ = 1 << PG_AW;
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  logic [7:0]              mem   [DEPTH];
  logic [7:0]              pgBuf [PG_SZ];
  logic [PG_SZ-1:0]        pgVal;
  logic [MEM_AW-PG_AW-1:0] pgBase;
  logic                    wpen, flb, wel;
  logic [1:0]              wd, bl;
  logic [CNT_W-1:0]        cnt;
  logic                    busy;

  function automatic logic isLocked(input logic [MEM_AW-1:0] a, input logic [1:0] lk);
    case (lk)
      2'b00:   return 1'b0;
      2'b01:   return a[MEM_AW-1:MEM_AW-2] == 2'b11;
      2'b10:   return a[MEM_AW-1];
      default: return 1'b1;
    endcase
  endfunction

  assign busy      = (cnt != '0);
  assign rdByte    = mem[rdAddr];
  assign statusOut = {wpen, flb, wd, bl, wel, busy};
  assign wdSel     = wd;
  assign flagOut   = flb;

  always_ff @(posedge clk) begin
    if (str.bufWr) pgBuf[str.bufAddr[PG_AW-1:0]] <= str.bufData;
    if (str.memCommit) begin
      for (int i = 0; i < PG_SZ; i++) begin
        if (pgVal[i] && !isLocked({pgBase, PG_AW'(i)}, bl))
          mem[{pgBase, PG_AW'(i)}] <= pgBuf[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pgVal <= '0; pgBase <= '0; wpen <= 1'b0; flb <= 1'b0;
      wd <= '0;    bl <= '0;     wel <= 1'b0;  cnt <= '0;
    end else begin
      if (str.bufClr) begin
        pgVal  <= '0;
        pgBase <= str.bufAddr[MEM_AW-1:PG_AW];
      end
      if (str.bufWr) pgVal[str.bufAddr[PG_AW-1:0]] <= 1'b1;
      if (str.memCommit || str.statWr) cnt <= CNT_W'(BUSY_CYCLES);
      else if (busy) cnt <= cnt - 1'b1;
      if (str.setWel) wel <= 1'b1;
      else if (str.clrWel || cnt == CNT_W'(1)) wel <= 1'b0;
      if (str.statWr) {wpen, flb, wd, bl} <= str.statBits;
      else if (str.setFlag) flb <= 1'b1;
      else if (str.clrFlag) flb <= 1'b0;
    end
  end

  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(str.setWel || str.setFlag || str.bufWr || str.memCommit || str.statWr)); // R10
  AST_COMMIT_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rstN)
    str.memCommit |-> wel); // R7
  AST_WIP_STARTS: assert property (@(posedge clk) disable iff (!rstN)
    (str.memCommit || str.statWr) |=> busy); // R9
  AST_WEL_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !wel); // R9
  AST_ROM_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    str.statWr |-> !(wpen && !wpN)); // R13
endmodule

// File: rtl/serial_mem_ctrl.sv
module serial_mem_ctrl
  import smc_pkg::*;
#(
  parameter int BUSY_CYCLES = 400
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sck,
  input  logic       si,
  input  logic       wpN,
  output logic       so,
  output logic       soEn,
  output logic [1:0] wdSel,
  output logic       flagOut
);
  dpStrobe_t         str;
  logic [7:0]        statusByte, rdByte;
  logic [MEM_AW-1:0] rdAddr;

  assign soEn = !csN;

  smc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si), .wpN(wpN),
    .statusIn(statusByte), .rdByte(rdByte), .rdAddr(rdAddr), .str(str), .so(so)
  );

  smc_dp #(.BUSY_CYCLES(BUSY_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .wpN(wpN), .str(str), .rdAddr(rdAddr),
    .rdByte(rdByte), .statusOut(statusByte), .wdSel(wdSel), .flagOut(flagOut)
  );
endmodule

// File: tb/serial_mem_ctrl_bench.sv
module serial_mem_ctrl_bench;
  localparam int BUSY = 400;

  logic clk = 1'b0, rstN = 1'b0, csN = 1'b1, sck = 1'b0, si = 1'b0, wpN = 1'b1;
  logic so, soEn, flagOut;
  logic [1:0] wdSel;

  int nChk = 0, nBad = 0;
  bit m3 = 1'b0, done = 1'b0;
  logic [7:0] expQ[$], gotQ[$];
  string tagQ[$];

  always #2 clk = ~clk;

  serial_mem_ctrl #(.BUSY_CYCLES(BUSY)) u_serial_mem_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si), .wpN(wpN),
    .so(so), .soEn(soEn), .wdSel(wdSel), .flagOut(flagOut)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startTxn();
    sck = m3; waitClk(2); csN = 1'b0; waitClk(4);
  endtask

  task automatic endTxn();
    if (!m3) sck = 1'b0;
    waitClk(4); csN = 1'b1; waitClk(4); sck = m3; waitClk(2);
  endtask

  task automatic xfer(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nb; i--) begin
      sck = 1'b0; si = tx[i]; waitClk(4);
      rx = {rx[6:0], so};
      sck = 1'b1; waitClk(4);
    end
  endtask

  task automatic send(input logic [7:0] tx);
    logic [7:0] d;
    xfer(tx, 8, d);
  endtask

  task automatic expect1(input logic [7:0] v, input string tag);
    expQ.push_back(v); tagQ.push_back(tag);
  endtask

  task automatic grab();
    logic [7:0] r;
    xfer(8'h00, 8, r);
    gotQ.push_back(r);
  endtask

  task automatic cmd(input logic [7:0] op);
    startTxn(); send(op); endTxn();
  endtask

  task automatic rdsr(input logic [7:0] exp, input string tag);
    expect1(exp, tag);
    startTxn(); send(8'h05); grab(); endTxn();
  endtask

  task automatic wrsr(input logic [7:0] v);
    startTxn(); send(8'h01); send(v); endTxn();
  endtask

  task automatic writeSeq(input logic [15:0] a, input logic [7:0] d0, input logic [7:0] d1,
                          input logic [7:0] d2, input logic [7:0] d3, input int n);
    logic [7:0] d [4];
    d[0] = d0; d[1] = d1; d[2] = d2; d[3] = d3;
    startTxn(); send(8'h02); send(a[15:8]); send(a[7:0]);
    for (int i = 0; i < n; i++) send(d[i]);
    endTxn();
  endtask

  task automatic readExp(input logic [15:0] a, input logic [7:0] e0, input logic [7:0] e1,
                         input int n, input string tag);
    expect1(e0, tag);
    if (n > 1) expect1(e1, tag);
    startTxn(); send(8'h03); send(a[15:8]); send(a[7:0]);
    for (int i = 0; i < n; i++) grab();
    endTxn();
  endtask

  task automatic waitIdle();
    waitClk(BUSY + 60);
  endtask

  // monitor: pops results in order and judges them against the driver's expectations
  always @(negedge clk) begin
    if (gotQ.size() > 0 && expQ.size() > 0) begin
      logic [7:0] g, e;
      string t;
      g = gotQ.pop_front(); e = expQ.pop_front(); t = tagQ.pop_front();
      check(g == e, t, g, e);
    end
  end

  initial begin
    logic [7:0] r;
    waitClk(5); rstN = 1'b1; waitClk(3);
    // R1 reset state
    check(soEn == 1'b0, "R1 soEn", soEn, 0);
    check(wdSel == 2'd0, "R1 wdSel", wdSel, 0);
    check(flagOut == 1'b0, "R1 flagOut", flagOut, 0);
    rdsr(8'h00, "R1");
    // R2 / R5 output enable and continuous status stream
    startTxn();
    check(soEn == 1'b1, "R2 soEn selected", soEn, 1);
    send(8'h05); expect1(8'h00, "R2"); grab(); expect1(8'h00, "R5"); grab();
    endTxn();
    check(soEn == 1'b0, "R2 soEn idle", soEn, 0);
    // R3 enable latch rules
    startTxn(); send(8'h06); xfer(8'h00, 1, r); endTxn();
    rdsr(8'h00, "R3 extra clock voids");
    cmd(8'h06); rdsr(8'h02, "R3 set");
    cmd(8'h04); rdsr(8'h00, "R3 clear");
    // R4 flag
    cmd(8'h00);
    check(flagOut == 1'b1, "R4 flagOut", flagOut, 1);
    rdsr(8'h40, "R4");
    cmd(8'h06); rdsr(8'h42, "R4 with latch");
    cmd(8'h04);
    check(flagOut == 1'b0, "R3 flag cleared", flagOut, 0);
    rdsr(8'h00, "R3 both cleared");
    // R7 page write with wrap, R9 busy window, R10 ignored opcode during busy
    cmd(8'h06);
    writeSeq(16'h001E, 8'hAA, 8'hBB, 8'hCC, 8'hDD, 4);
    rdsr(8'h03, "R9 busy");
    cmd(8'h00);
    waitIdle();
    check(flagOut == 1'b0, "R10 flag set ignored", flagOut, 0);
    rdsr(8'h00, "R9 latch cleared");
    readExp(16'h001E, 8'hAA, 8'hBB, 2, "R7");
    readExp(16'h0000, 8'hCC, 8'hDD, 2, "R7 page wrap");
    // R8 abort off byte boundary
    cmd(8'h06); writeSeq(16'h0040, 8'h11, 8'h00, 8'h00, 8'h00, 1); waitIdle();
    cmd(8'h06);
    startTxn(); send(8'h02); send(8'h00); send(8'h40); send(8'h55); xfer(8'hFF, 3, r); endTxn();
    rdsr(8'h02, "R8 latch kept");
    readExp(16'h0040, 8'h11, 8'h00, 1, "R8 store unchanged");
    cmd(8'h04);
    // R6 top-of-store wrap with ignored upper address bits
    cmd(8'h06); writeSeq(16'h07FF, 8'h9C, 8'h00, 8'h00, 8'h00, 1); waitIdle();
    readExp(16'hF7FF, 8'h9C, 8'hCC, 2, "R6");
    // R12 status write, low bits discarded
    cmd(8'h06); wrsr(8'h37); waitIdle();
    rdsr(8'h34, "R12");
    check(wdSel == 2'd3, "R12 wdSel", wdSel, 3);
    // R11 lock field 01 guards 0x600..0x7FF
    cmd(8'h06); writeSeq(16'h07FF, 8'h44, 8'h00, 8'h00, 8'h00, 1); waitIdle();
    cmd(8'h06); writeSeq(16'h05FF, 8'h66, 8'h00, 8'h00, 8'h00, 1); waitIdle();
    readExp(16'h07FF, 8'h9C, 8'h00, 1, "R11 protected");
    readExp(16'h05FF, 8'h66, 8'h00, 1, "R11 open");
    // R13 status lock with wpN
    cmd(8'h06); wrsr(8'hB4); waitIdle();
    rdsr(8'hB4, "R13 accepted");
    wpN = 1'b0;
    cmd(8'h06); wrsr(8'h00); waitClk(20);
    rdsr(8'hB6, "R13 refused");
    wpN = 1'b1;
    wrsr(8'h00); waitIdle();
    rdsr(8'h00, "R13 released");
    check(wdSel == 2'd0, "R13 wdSel", wdSel, 0);
    // R2 clock mode 3
    m3 = 1'b1; sck = 1'b1; waitClk(4);
    expect1(8'h00, "R2 mode3");
    startTxn(); send(8'h05); grab(); endTxn();
    cmd(8'h06); rdsr(8'h02, "R2 mode3 latch");
    cmd(8'h04);
    m3 = 1'b0; sck = 1'b0;
    waitClk(10);
    if (expQ.size() != 0 || gotQ.size() != 0)
      check(1'b0, "scoreboard residue", gotQ.size(), expQ.size());
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end
endmodule